// File: doc/BRIEF.md
# AES3 Subframe Framer with Stereo and Mono Packing

The framer turns parallel 24-bit audio words into a biphase-mark coded AES3 line signal on a differential pair. A divider derives a half-cell enable from the master clock, so one frame takes 128 half-cells. Each frame holds two subframes of 32 slots. Every subframe starts with a preamble, then carries the audio sample with the least significant bit first, then the validity, user and channel-status bits sampled from pins, and ends with an even-parity bit. A counter groups frames into 192-frame blocks. The first subframe of block frame 0 carries the Z preamble, every other first subframe carries X, and every second subframe carries Y.

In stereo mode the left word fills the first subframe and the right word fills the second. In mono mode the input word rate is twice the frame rate. A select input picks one channel of each word, and consecutive picked samples fill consecutive subframes. The framer also outputs a sampling reference clock with a 50% duty cycle. This clock runs at the frame rate in stereo mode and at twice the frame rate in mono mode, and a polarity input inverts it. The block boundary either comes from the framer's own counter, which then drives a block-start output, or from an external block-start input that restarts the count.

Top module: `aes3_framer`

## Requirements
- R1: While reset is low, and until the first half-cell enable after reset, `txP` is 0 and `txN` is 1. The first subframe sent after reset carries the Z preamble.
- R2: The line changes only on the half-cell enable, which fires once every `CLK_DIV` master clocks (the first time on the `CLK_DIV`-th clock after reset). A subframe is 64 half-cells and a frame is 128.
- R3: The preambles occupy half-cells 0 to 7 of a subframe. Written as line levels, with the first half-cell leftmost and starting from a low line, they are Z = 11101000, X = 11100010 and Y = 11100100. All levels are inverted when the line is high at the subframe start. The first subframe uses Z in block frame 0 and X otherwise, and the second subframe uses Y.
- R4: Slots 4 to 27 carry the audio sample with the LSB first. Slot 28 carries V, slot 29 U and slot 30 C. Slot 31 is a parity bit that makes slots 4 to 31 hold an even number of ones.
- R5: In slots 4 to 31 the line toggles at the start of every slot. It toggles again at mid-slot exactly when the bit is 1.
- R6: In stereo mode (`monoMode`=0), the first subframe carries `sampleLeft` and the second carries `sampleRight`, both taken at the start of the first subframe. `vBit`, `uBit` and `cBit` are taken at the start of each subframe.
- R7: In mono mode (`monoMode`=1), each subframe carries the channel picked by `monoSel` (0 picks `sampleLeft`, 1 picks `sampleRight`), taken at the start of that subframe.
- R8: `wordClk` is high in the first half of its period. In stereo mode the period is 128 half-cells and in mono mode it is 64 half-cells. `wordClkPol`=1 inverts it.
- R9: Frames count modulo 192. With `blockSrc`=1, `blockOut` is high for the whole of block frame 0 and low otherwise. With `blockSrc`=0, `blockOut` stays low.
- R10: With `blockSrc`=0, a rising edge on `blockIn` held for at least 4 master clocks makes the next frame block frame 0, which carries Z. With `blockSrc`=1, `blockIn` has no effect.
- R11: `txN` is always the complement of `txP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous reset, active low |
| monoMode | input | 1 | 0 stereo, 1 mono packing |
| monoSel | input | 1 | Mono channel pick: 0 left, 1 right |
| wordClkPol | input | 1 | Inverts the sampling reference clock |
| blockSrc | input | 1 | 1: internal block counter is the source; 0: follow blockIn |
| blockIn | input | 1 | External block-start marker |
| sampleLeft | input | 24 | Left (even) audio word |
| sampleRight | input | 24 | Right (odd) audio word |
| vBit | input | 1 | Validity bit for the next subframe |
| uBit | input | 1 | User bit for the next subframe |
| cBit | input | 1 | Channel-status bit for the next subframe |
| wordClk | output | 1 | Sampling reference clock |
| blockOut | output | 1 | High during block frame 0 when the framer is the source |
| txP | output | 1 | Line output, true side |
| txN | output | 1 | Line output, complement side |

## Verification
The hardest case to reach from the ports is the frame-counter wrap. A 192-frame block must pass before the Z preamble and `blockOut` come back, so the bench runs one full block in stereo mode and checks the preamble captured at the wrap. A second hard case is the external restart, which needs a `blockIn` pulse mid-frame in follower mode. The bench also sends the same pulse while the framer is the source and checks that the next preamble is still X. The bench model rebuilds each subframe behaviourally from the inputs it sees at each subframe start and compares the line on every clock. The stimulus steps through random, all-zero, all-one and alternating words, so that parity and mid-cell toggles take both values.

// File: rtl/aes3_pkg.sv
package aes3_pkg;
  localparam int AUDIO_W  = 24;
  localparam int PAY_W    = AUDIO_W + 4;
  localparam int PRE_SLOT = 4;

  typedef enum logic [1:0] {PRE_X = 2'd0, PRE_Y = 2'd1, PRE_Z = 2'd2} preKind_t;

  typedef struct packed {
    logic     halfEn;   // one half-cell elapses
    logic     sfStart;  // half-cell 0 of a subframe
    logic     sfIdx;    // 0 first subframe, 1 second
    logic [5:0] sfHalf; // half-cell index within subframe
    preKind_t pre;      // preamble for this subframe
  } strobe_t;

  // Per-half-cell toggle masks for the preambles, bit i = half-cell i.
  function automatic logic [7:0] preToggles(input preKind_t kind);
    case (kind)
      PRE_Z:   preToggles = 8'b0011_1001;
      PRE_Y:   preToggles = 8'b0110_1001;
      default: preToggles = 8'b1100_1001;
    endcase
  endfunction
endpackage

// File: rtl/aes3_ctrl.sv
module aes3_ctrl
  import aes3_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    monoMode,
  input  logic    wordClkPol,
  input  logic    blockSrc,
  input  logic    blockIn,
  output strobe_t strb,
  output logic    wordClk,
  output logic    blockOut
);
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_W = $clog2(BLOCK_FRAMES);

  logic [DIV_W-1:0]   divCnt;
  logic [6:0]         halfIdx;
  logic [FRAME_W-1:0] frameCnt;
  logic [2:0]         syncIn;
  logic               pendStart;
  logic               halfEn;
  logic               frameEnd;
  logic               startRise;

  assign halfEn    = (divCnt == DIV_W'(CLK_DIV - 1));
  assign frameEnd  = halfEn && (&halfIdx);
  assign startRise = syncIn[1] && !syncIn[2] && !blockSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      halfIdx   <= '0;
      frameCnt  <= '0;
      syncIn    <= '0;
      pendStart <= 1'b0;
    end else begin
      syncIn <= {syncIn[1:0], blockIn};
      divCnt <= halfEn ? '0 : divCnt + 1'b1;
      if (halfEn) halfIdx <= halfIdx + 7'd1;
      if (frameEnd) begin
        pendStart <= 1'b0;
        if (!blockSrc && pendStart)                          frameCnt <= '0;
        else if (frameCnt == FRAME_W'(BLOCK_FRAMES - 1))     frameCnt <= '0;
        else                                                 frameCnt <= frameCnt + 1'b1;
      end
      if (startRise) pendStart <= 1'b1;
    end
  end

  always_comb begin
    strb.halfEn  = halfEn;
    strb.sfStart = halfEn && (halfIdx[5:0] == 6'd0);
    strb.sfIdx   = halfIdx[6];
    strb.sfHalf  = halfIdx[5:0];
    if (halfIdx[6])             strb.pre = PRE_Y;
    else if (frameCnt == '0)    strb.pre = PRE_Z;
    else                        strb.pre = PRE_X;
  end

  assign wordClk  = (monoMode ? ~halfIdx[5] : ~halfIdx[6]) ^ wordClkPol;
  assign blockOut = blockSrc && (frameCnt == '0);
endmodule

// File: rtl/aes3_datapath.sv
module aes3_datapath
  import aes3_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               monoMode,
  input  logic               monoSel,
  input  logic [AUDIO_W-1:0] sampleLeft,
  input  logic [AUDIO_W-1:0] sampleRight,
  input  logic               vBit,
  input  logic               uBit,
  input  logic               cBit,
  output logic               txP,
  output logic               txN
);
  logic [PAY_W-1:0]   payload;
  logic [AUDIO_W-1:0] rightHold;
  logic [AUDIO_W-1:0] pickSample;
  logic [PAY_W-2:0]   bodyBits;
  logic [4:0]         slot;
  logic [4:0]         bitPos;
  logic               toggle;

  always_comb begin
    if (monoMode)        pickSample = monoSel ? sampleRight : sampleLeft;
    else if (strb.sfIdx) pickSample = rightHold;
    else                 pickSample = sampleLeft;
  end

  assign bodyBits = {cBit, uBit, vBit, pickSample};
  assign slot     = strb.sfHalf[5:1];
  assign bitPos   = slot - 5'(PRE_SLOT);

  always_comb begin
    if (slot < 5'(PRE_SLOT))  toggle = preToggles(strb.pre)[strb.sfHalf[2:0]];
    else if (!strb.sfHalf[0]) toggle = 1'b1;
    else                      toggle = payload[bitPos];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payload   <= '0;
      rightHold <= '0;
      txP       <= 1'b0;
      txN       <= 1'b1;
    end else begin
      if (strb.sfStart) begin
        payload <= {^bodyBits, bodyBits};
        if (!strb.sfIdx) rightHold <= sampleRight;
      end
      if (strb.halfEn) begin
        txP <= txP ^ toggle;
        txN <= ~(txP ^ toggle);
      end
    end
  end
endmodule

// File: rtl/aes3_framer.sv
module aes3_framer
  import aes3_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               monoMode,
  input  logic               monoSel,
  input  logic               wordClkPol,
  input  logic               blockSrc,
  input  logic               blockIn,
  input  logic [AUDIO_W-1:0] sampleLeft,
  input  logic [AUDIO_W-1:0] sampleRight,
  input  logic               vBit,
  input  logic               uBit,
  input  logic               cBit,
  output logic               wordClk,
  output logic               blockOut,
  output logic               txP,
  output logic               txN
);
  strobe_t strb;

  aes3_ctrl #(.CLK_DIV(CLK_DIV), .BLOCK_FRAMES(BLOCK_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .monoMode(monoMode), .wordClkPol(wordClkPol),
    .blockSrc(blockSrc), .blockIn(blockIn), .strb(strb),
    .wordClk(wordClk), .blockOut(blockOut)
  );

  aes3_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .monoMode(monoMode), .monoSel(monoSel),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .vBit(vBit), .uBit(uBit), .cBit(cBit), .txP(txP), .txN(txN)
  );
endmodule

// File: rtl/aes3_framer_chk.sv
module aes3_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       halfEn,
  input logic [6:0] halfIdx,
  input logic       txP,
  input logic       txN,
  input logic       blockOut,
  input logic       blockSrc,
  input logic       wordClk,
  input logic       wordClkPol,
  input logic       monoMode
);
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !halfEn |=> $stable(txP));

  assert_cell_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (halfEn && !halfIdx[0] && (halfIdx[5:3] != 3'd0)) |=> (txP != $past(txP)));

  assert_pair_R11: assert property (@(posedge clk) disable iff (!rstN)
    txN != txP);

  assert_wordclk_R8: assert property (@(posedge clk) disable iff (!rstN)
    !halfEn |=> ($stable(wordClk) || !$stable(wordClkPol) || !$stable(monoMode)));

  assert_block_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(halfEn && (&halfIdx)) |=> ($stable(blockOut) || !$stable(blockSrc)));
endmodule

bind aes3_framer aes3_framer_chk u_chk (
  .clk(clk), .rstN(rstN), .halfEn(strb.halfEn), .halfIdx({strb.sfIdx, strb.sfHalf}),
  .txP(txP), .txN(txN), .blockOut(blockOut), .blockSrc(blockSrc),
  .wordClk(wordClk), .wordClkPol(wordClkPol), .monoMode(monoMode)
);

// File: tb/sim_aes3_framer.sv
`timescale 1ns/1ps
module sim_aes3_framer;
  localparam int DIV = 4;
  localparam int FRAMES = 192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic monoMode = 1'b0, monoSel = 1'b0, wordClkPol = 1'b0;
  logic blockSrc = 1'b1, blockIn = 1'b0;
  logic [23:0] sampleLeft = '0, sampleRight = '0;
  logic vBit = 1'b0, uBit = 1'b0, cBit = 1'b0;
  logic wordClk, blockOut, txP, txN;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aes3_framer u0 (
    .clk(clk), .rstN(rstN), .monoMode(monoMode), .monoSel(monoSel),
    .wordClkPol(wordClkPol), .blockSrc(blockSrc), .blockIn(blockIn),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .vBit(vBit), .uBit(uBit), .cBit(cBit),
    .wordClk(wordClk), .blockOut(blockOut), .txP(txP), .txN(txN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int n = 0, divc = 0, mFrame = 0, lastHs = 0;
  bit level = 0, base = 0, pending = 0, prevIn = 0;
  bit bits[28];
  logic [23:0] holdR = '0;
  logic [7:0] curPat = 8'b11101000;
  localparam logic [7:0] PAT_Z = 8'b11101000;
  localparam logic [7:0] PAT_X = 8'b11100010;
  localparam logic [7:0] PAT_Y = 8'b11100100;

  always @(posedge clk) begin
    if (!rstN) begin
      n = 0; divc = 0; mFrame = 0; level = 0; pending = 0; prevIn = 0; lastHs = 0;
    end else begin
      if (!blockSrc && blockIn && !prevIn) pending = 1;
      prevIn = blockIn;
      if (divc == DIV - 1) begin
        int h, hs;
        divc = 0;
        h = n % 128;
        hs = h % 64;
        if (hs == 0) begin
          logic [23:0] s;
          int ones;
          base = level;
          if (monoMode) s = monoSel ? sampleRight : sampleLeft;
          else if (h == 0) s = sampleLeft;
          else s = holdR;
          if (h == 0) holdR = sampleRight;
          ones = 0;
          for (int i = 0; i < 24; i++) begin bits[i] = s[i]; ones += s[i]; end
          bits[24] = vBit; bits[25] = uBit; bits[26] = cBit;
          ones += vBit + uBit + cBit;
          bits[27] = ones[0];
          curPat = (h != 0) ? PAT_Y : ((mFrame == 0) ? PAT_Z : PAT_X);
        end
        if (hs < 8) level = base ^ curPat[7 - hs];
        else if (hs % 2 == 0) level = !level;
        else if (bits[hs / 2 - 4]) level = !level;
        lastHs = hs;
        if (h == 127) begin
          if (!blockSrc && pending) mFrame = 0;
          else mFrame = (mFrame + 1) % FRAMES;
          pending = 0;
        end
        n++;
      end else divc++;
    end
  end

  // Per-clock comparison (R2 timing of line changes is covered here too)
  always @(negedge clk) begin
    if (rstN && !done) begin
      int hn;
      bit expW;
      string tag;
      hn = n % 128;
      expW = (monoMode ? !hn[5] : !hn[6]) ^ wordClkPol;
      if (lastHs < 8) tag = "R3";
      else if (lastHs >= 56) tag = "R4";
      else tag = monoMode ? "R7/R5" : "R6/R5";
      check(txP == level, tag, txP, level);
      check(txN == !level, "R11", txN, !level);
      check(wordClk == expW, "R8", wordClk, expW);
      check(blockOut == (blockSrc && mFrame == 0), "R9", blockOut, blockSrc && mFrame == 0);
    end
  end

  // Data stimulus: pattern class changes with frame number
  always @(posedge clk) begin
    #1;
    case (mFrame % 4)
      0: begin sampleLeft = 24'($urandom); sampleRight = 24'($urandom); end
      1: begin sampleLeft = '0; sampleRight = '0; end
      2: begin sampleLeft = '1; sampleRight = '1; end
      default: begin sampleLeft = 24'hA5A5A5 ^ 24'(n); sampleRight = 24'h5A5A5A; end
    endcase
    vBit = 1'($urandom); uBit = 1'($urandom); cBit = 1'($urandom);
  end

  // Capture the 8 preamble levels at the next frame start
  task automatic capPre(output logic [7:0] lv);
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while ((n % 128) != i + 1);
      lv[7 - i] = txP;
    end
  endtask

  function automatic bit preOk(input logic [7:0] lv, input logic [7:0] pat);
    return lv == (lv[7] ? pat : ~pat);
  endfunction

  task automatic pulseAt40();
    do @(negedge clk); while ((n % 128) != 40);
    @(posedge clk); #1 blockIn = 1;
    repeat (5) @(posedge clk);
    #1 blockIn = 0;
  endtask

  task automatic runFrames(input int k);
    repeat (k * 128 * DIV) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] lv;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(txP == 1'b0, "R1 reset txP", txP, 0);
    check(txN == 1'b1, "R1 reset txN", txN, 1);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    check(txP == 1'b0, "R1 idle before first half-cell", txP, 0);
    capPre(lv);
    check(preOk(lv, PAT_Z), "R1 first preamble Z", lv, PAT_Z);
    capPre(lv);
    check(preOk(lv, PAT_X), "R3 frame 1 preamble X", lv, PAT_X);
    // blockIn ignored while the framer is the source
    do @(negedge clk); while (mFrame != 3);
    pulseAt40();
    capPre(lv);
    check(preOk(lv, PAT_X), "R10 blockIn ignored, X kept", lv, PAT_X);
    check(blockOut == 1'b0, "R10 blockOut low after ignored pulse", blockOut, 0);
    // wait for the block wrap
    do @(negedge clk); while (n != 128 * FRAMES - 2);
    capPre(lv);
    check(preOk(lv, PAT_Z), "R9 Z after 192 frames", lv, PAT_Z);
    check(blockOut == 1'b1, "R9 blockOut high at wrap", blockOut, 1);
    // mono mode, both picks, inverted reference clock
    @(posedge clk); #1 monoMode = 1; monoSel = 0; wordClkPol = 1;
    runFrames(12);
    monoSel = 1;
    runFrames(12);
    wordClkPol = 0;
    runFrames(2);
    monoMode = 0;
    runFrames(1);
    // follower mode
    do @(negedge clk); while ((n % 128) != 20 || mFrame == 0);
    @(posedge clk); #1 blockSrc = 0;
    runFrames(2);
    do @(negedge clk); while (mFrame == 0);
    pulseAt40();
    capPre(lv);
    check(preOk(lv, PAT_Z), "R10 external restart gives Z", lv, PAT_Z);
    check(blockOut == 1'b0, "R9 blockOut low in follower mode", blockOut, 0);
    runFrames(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule